// File: doc/BRIEF.md
# Byte-Lane Pseudo-Static Memory Model

This block is a synthesizable behavioural model of a word-organised pseudo-static memory that has an asynchronous strobe interface. A fast system clock samples every strobe, and the model reacts to the edges it sees between two samples. A cycle opens when chip enable falls, which also latches the address. While the cycle is open, each of the two byte lanes independently reads, writes or stays quiet, according to its own output-enable and write-strobe pins. Write data for a lane is taken when that lane's strobe rises, or when chip enable rises while the strobe is still low. The data bus is split into an input word, an output word and one drive-enable per lane.

The model also tracks the memory's refresh needs. A cycle in which neither lane reads or writes counts as a refresh of the row given by the low eight address bits. With chip enable high, a low level on the lower output-enable pin starts a self-timed refresh of the row named by an internal 8-bit counter. Both kinds of refresh advance that counter. Each row keeps its own age timer. A sticky flag rises if any row goes unrefreshed for the whole retention window. A second sticky flag rises if chip enable is held low for too long. All times are parameters in nanoseconds and are converted to clock ticks.

The default depth is kept small for elaboration. Setting `ADDR_W` to 15 gives the full 32K-word array.

Top module: `psram_lane_model`

## Requirements
- R1: After a synchronous reset (rst_n_i low at a clock edge), both drive enables are 0 and both sticky flags are 0.
- R2: The address is taken at the clock edge where chip enable is first seen low. Address changes later in the same cycle do not change which word is read or written.
- R3: Lane n (index 0 = bits 7:0, index 1 = bits 15:8) drives when chip enable is low, oe_n_i[n] is low and we_n_i[n] is high. It presents the stored byte one clock after the edge that sees those levels.
- R4: With chip enable low, a rising we_n_i[n] writes din_i lane n, as sampled at the edge that sees the strobe high, into the latched word. The other lane is left unchanged.
- R5: If chip enable rises while we_n_i[n] is still low, lane n is written with din_i sampled at the edge that sees chip enable high.
- R6: The lanes are independent. One lane can write while the other reads in the same cycle. A lane whose write strobe is low is never driven.
- R7: While chip enable is high, neither lane drives and nothing is written, whatever the address, write strobes and data inputs are doing.
- R8: A chip-enable cycle in which no lane read or wrote is a refresh. It refreshes the row given by the latched address bits 7:0, advances the refresh counter by one, drives nothing and leaves the contents unchanged.
- R9: With chip enable high, the first edge at which oe_n_i[0] is seen low starts an auto refresh. It refreshes the row named by the 8-bit counter (which starts at 0 after reset), and the counter then advances by one, wrapping from 255 to 0.
- R10: If a refresh-only cycle ends at the same edge that an auto refresh starts, the auto refresh takes the current counter row, the other refresh takes its address row, and the counter advances by two.
- R11: rfsh_late_o is set, and stays set until reset, once any row has gone REF_NS/CLK_NS clock ticks without a refresh.
- R12: ce_long_o is set, and stays set until reset, once chip enable has been sampled low on more than CE_NS/CLK_NS consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| ce_n_i | input | 1 | Active-low chip enable |
| addr_i | input | ADDR_W | Word address |
| oe_n_i | input | 2 | Active-low output enable per lane; bit 0 doubles as the auto-refresh request |
| we_n_i | input | 2 | Active-low write strobe per lane |
| din_i | input | 16 | Write data from the bus |
| dout_o | output | 16 | Read data towards the bus |
| doe_o | output | 2 | Per-lane drive enable of dout_o |
| rfsh_late_o | output | 1 | Sticky refresh-starvation flag |
| ce_long_o | output | 1 | Sticky over-long chip-enable flag |

## Verification
Two refresh sources can land on the same clock edge: the end of a refresh-only chip-enable cycle and the start of an auto refresh. The bench provokes this by raising chip enable on the same edge that pulls the lower output enable low, with address 1, after about 30,000 idle ticks. It then issues 254 plain auto refreshes. The result is judged from the starvation flag alone. It must stay clear past the window measured from reset, because every row, including row 1, was covered only if both rows were refreshed and the counter skipped by two. It must then rise once the window has passed after that sweep. A second overlap, a lane read alongside a write in the other lane, is judged by the drive enables and the read byte.

// File: rtl/psram_pkg.sv
// Package: shared lane count, lane width and per-lane mode type for the
// pseudo-static memory model. Assumes a 16-bit word made of two byte lanes.
package psram_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        LANE_IDLE  = 2'd0,
        LANE_READ  = 2'd1,
        LANE_WRITE = 2'd2
    } lane_mode_e;
endpackage

// File: rtl/psram_strobe_ctrl.sv
// Strobe decoder: turns sampled strobe levels into clocked events.
// It latches the address when chip enable falls and decodes each lane's mode.
// It raises per-lane write pulses on strobe or chip-enable rising edges and
// flags the two refresh sources.
// Assumes every strobe level lasts at least one clock period.
module psram_strobe_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int ROW_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              ce_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANES-1:0]  oe_n_i,
    input  logic [LANES-1:0]  we_n_i,
    output logic [ADDR_W-1:0] addr_q_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [LANES-1:0]  rd_en_o,
    output logic [LANES-1:0]  wr_en_o,
    output logic              ceonly_ev_o,
    output logic [ROW_W-1:0]  ceonly_row_o,
    output logic              auto_ev_o
);
    logic              ce_q;
    logic [LANES-1:0]  we_q;
    logic              acc_q;
    logic              auto_q;
    logic [ADDR_W-1:0] addr_q;
    lane_mode_e        mode [LANES];
    logic [LANES-1:0]  act_now;
    logic              ce_fall, ce_rise, auto_now;

    assign ce_fall  = ce_q & ~ce_n_i;
    assign ce_rise  = ~ce_q & ce_n_i;
    assign auto_now = ce_n_i & ~oe_n_i[0];

    // Per-lane mode decode from the present strobe levels.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            if (ce_n_i)          mode[l] = LANE_IDLE;
            else if (!we_n_i[l]) mode[l] = LANE_WRITE;
            else if (!oe_n_i[l]) mode[l] = LANE_READ;
            else                 mode[l] = LANE_IDLE;
            rd_en_o[l] = (mode[l] == LANE_READ);
            act_now[l] = (mode[l] != LANE_IDLE);
            // Write when the strobe was low inside the cycle and either it or chip enable has risen.
            wr_en_o[l] = ~ce_q & ~we_q[l] & (we_n_i[l] | ce_n_i);
        end
    end

    // Previous-sample registers used for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            ce_q   <= 1'b1;
            we_q   <= '1;
            auto_q <= 1'b0;
        end else begin
            ce_q   <= ce_n_i;
            we_q   <= we_n_i;
            auto_q <= auto_now;
        end
    end

    // Address latch on chip-enable fall; access flag gathered over the cycle.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            addr_q <= '0;
            acc_q  <= 1'b0;
        end else if (ce_fall) begin
            addr_q <= addr_i;
            acc_q  <= |act_now;
        end else if (!ce_n_i) begin
            acc_q  <= acc_q | (|act_now);
        end
    end

    assign addr_q_o     = addr_q;
    assign rd_addr_o    = ce_fall ? addr_i : addr_q;
    assign ceonly_ev_o  = ce_rise & ~acc_q;
    assign ceonly_row_o = addr_q[ROW_W-1:0];
    assign auto_ev_o    = auto_now & ~auto_q;

    // R2: the latched address stays put while the cycle stays open.
    assert_addr_held_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!ce_n_i && !ce_fall) |=> (addr_q == $past(addr_q)));
endmodule

// File: rtl/psram_array.sv
// Word array with per-lane byte writes and one registered read port.
// Write pulses use the latched address. A read samples the address given by
// the strobe decoder and drives its lane one clock later.
// Assumes write and read never target the same lane in one cycle.
module psram_array
    import psram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [LANES-1:0]  wr_en_i,
    input  logic [WORD_W-1:0] din_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [LANES-1:0]  rd_en_i,
    output logic [WORD_W-1:0] dout_o,
    output logic [LANES-1:0]  doe_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;
    logic [LANES-1:0]  doe_q;

    // Byte-lane writes into the storage.
    always_ff @(posedge clk_i) begin
        for (int l = 0; l < LANES; l++) begin
            if (wr_en_i[l]) mem[wr_addr_i][l*LANE_W +: LANE_W] <= din_i[l*LANE_W +: LANE_W];
        end
    end

    // Registered read word and per-lane drive enables.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            rd_q  <= '0;
            doe_q <= '0;
        end else begin
            rd_q  <= mem[rd_addr_i];
            doe_q <= rd_en_i;
        end
    end

    assign dout_o = rd_q;
    assign doe_o  = doe_q;
endmodule

// File: rtl/psram_refresh_track.sv
// Refresh bookkeeping: keeps the 8-bit auto-refresh row counter and one age
// timer per row, and watches how long chip enable stays low.
// It raises a sticky starvation flag and a sticky over-long-enable flag.
// Assumes at most one refresh of each kind per clock.
module psram_refresh_track #(
    parameter int ROW_W  = 8,
    parameter int CLK_NS = 10,
    parameter int REF_NS = 4_000_000,
    parameter int CE_NS  = 10_000
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             ce_n_i,
    input  logic             auto_ev_i,
    input  logic             ceonly_ev_i,
    input  logic [ROW_W-1:0] ceonly_row_i,
    output logic             rfsh_late_o,
    output logic             ce_long_o
);
    localparam int ROWS   = 1 << ROW_W;
    localparam int REF_LIM = REF_NS / CLK_NS;
    localparam int CE_LIM  = CE_NS / CLK_NS;
    localparam int AGE_W  = $clog2(REF_LIM + 1);
    localparam int CEC_W  = $clog2(CE_LIM + 1);

    logic [ROW_W-1:0] ref_cnt;
    logic [ROWS-1:0]  aged;
    logic [CEC_W-1:0] ce_cnt;
    logic             late_q, celong_q;

    // Refresh row counter: one step per refresh event, wrapping.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) ref_cnt <= '0;
        else          ref_cnt <= ref_cnt + {{(ROW_W-1){1'b0}}, auto_ev_i}
                                         + {{(ROW_W-1){1'b0}}, ceonly_ev_i};
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [AGE_W-1:0] age_r;
        logic             clr_r;
        assign clr_r = (auto_ev_i && ref_cnt == ROW_W'(r)) ||
                       (ceonly_ev_i && ceonly_row_i == ROW_W'(r));
        // Per-row age timer, cleared by a refresh and saturating at the limit.
        always_ff @(posedge clk_i) begin
            if (!rst_n_i || clr_r)          age_r <= '0;
            else if (age_r != AGE_W'(REF_LIM)) age_r <= age_r + 1'b1;
        end
        assign aged[r] = (age_r == AGE_W'(REF_LIM));
    end

    // Consecutive chip-enable-low counter, saturating.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || ce_n_i)             ce_cnt <= '0;
        else if (ce_cnt != CEC_W'(CE_LIM))  ce_cnt <= ce_cnt + 1'b1;
    end

    // Sticky violation flags.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            late_q   <= 1'b0;
            celong_q <= 1'b0;
        end else begin
            late_q   <= late_q | (|aged);
            celong_q <= celong_q | (!ce_n_i && ce_cnt == CEC_W'(CE_LIM));
        end
    end

    assign rfsh_late_o = late_q;
    assign ce_long_o   = celong_q;

    // R9: without a refresh event the counter holds.
    assert_cnt_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!auto_ev_i && !ceonly_ev_i) |=> (ref_cnt == $past(ref_cnt)));
    // R10: two coincident refresh events move the counter by two.
    assert_cnt_double_R10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (auto_ev_i && ceonly_ev_i) |=> (ref_cnt == $past(ref_cnt) + 2'd2));
    // R11: starvation flag is sticky.
    assert_late_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        late_q |=> late_q);
    // R12: over-long enable flag is sticky.
    assert_celong_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        celong_q |=> celong_q);
endmodule

// File: rtl/psram_lane_model.sv
// Top of the pseudo-static memory model: strobe decoder, byte-lane array and
// refresh tracker. Every input is taken to be synchronous to clk_i already.
// Requires ADDR_W >= ROW_W.
module psram_lane_model
    import psram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int ROW_W  = 8,
    parameter int CLK_NS = 10,
    parameter int REF_NS = 4_000_000,
    parameter int CE_NS  = 10_000
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              ce_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        oe_n_i,
    input  logic [1:0]        we_n_i,
    input  logic [15:0]       din_i,
    output logic [15:0]       dout_o,
    output logic [1:0]        doe_o,
    output logic              rfsh_late_o,
    output logic              ce_long_o
);
    logic [ADDR_W-1:0] addr_q, rd_addr;
    logic [LANES-1:0]  rd_en, wr_en;
    logic              ceonly_ev, auto_ev;
    logic [ROW_W-1:0]  ceonly_row;

    psram_strobe_ctrl #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_strobe (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .ce_n_i(ce_n_i), .addr_i(addr_i),
        .oe_n_i(oe_n_i), .we_n_i(we_n_i), .addr_q_o(addr_q), .rd_addr_o(rd_addr),
        .rd_en_o(rd_en), .wr_en_o(wr_en), .ceonly_ev_o(ceonly_ev),
        .ceonly_row_o(ceonly_row), .auto_ev_o(auto_ev)
    );

    psram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .wr_addr_i(addr_q), .wr_en_i(wr_en),
        .din_i(din_i), .rd_addr_i(rd_addr), .rd_en_i(rd_en),
        .dout_o(dout_o), .doe_o(doe_o)
    );

    psram_refresh_track #(.ROW_W(ROW_W), .CLK_NS(CLK_NS), .REF_NS(REF_NS), .CE_NS(CE_NS)) u_rfsh (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .ce_n_i(ce_n_i), .auto_ev_i(auto_ev),
        .ceonly_ev_i(ceonly_ev), .ceonly_row_i(ceonly_row),
        .rfsh_late_o(rfsh_late_o), .ce_long_o(ce_long_o)
    );

    // R7: chip enable high leaves both lanes undriven on the next clock.
    assert_idle_bus_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ce_n_i |=> (doe_o == 2'b00));
    // R6: a lane with its write strobe low is not driven.
    assert_writer_quiet_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!ce_n_i && !we_n_i[0]) |=> !doe_o[0]);
    assert_writer_quiet_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!ce_n_i && !we_n_i[1]) |=> !doe_o[1]);
endmodule

// File: tb/psram_lane_model_tb.sv
module psram_lane_model_tb;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n;
    logic [AW-1:0] addr;
    logic [1:0]    oe_n, we_n;
    logic [15:0]   din;
    logic [15:0]   dout;
    logic [1:0]    doe;
    logic          late, celong;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [15:0] model [256];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    psram_lane_model #(.ADDR_W(AW), .ROW_W(8), .CLK_NS(10), .REF_NS(400_000), .CE_NS(10_000)) u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .ce_n_i(ce_n), .addr_i(addr), .oe_n_i(oe_n),
        .we_n_i(we_n), .din_i(din), .dout_o(dout), .doe_o(doe),
        .rfsh_late_o(late), .ce_long_o(celong)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int a);
        logic [7:0] b = 8'(a);
        return {b ^ 8'hA5, b * 8'd7 + 8'd3};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 2'b11; we_n = 2'b11; din = '0; addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Full-word or masked write closed by the strobe rising.
    task automatic wr_word(input int a, input logic [15:0] v, input logic [1:0] lanes);
        @(negedge clk); ce_n = 1'b0; addr = AW'(a);
        @(negedge clk); we_n = ~lanes; din = v;
        @(negedge clk); we_n = 2'b11;
        @(negedge clk); ce_n = 1'b1; din = ~v;
        for (int l = 0; l < 2; l++)
            if (lanes[l]) model[a][l*8 +: 8] = v[l*8 +: 8];
    endtask

    // Read both lanes, then move the address and confirm it is ignored.
    task automatic rd_word(input int a);
        @(negedge clk); ce_n = 1'b0; addr = AW'(a); oe_n = 2'b00;
        @(negedge clk);
        chk("R3 drive", 32'(doe), 32'h3);
        chk("R3 data", 32'(dout), 32'(model[a]));
        addr = ~AW'(a);
        @(negedge clk);
        chk("R2 addr held", 32'(dout), 32'(model[a]));
        ce_n = 1'b1; oe_n = 2'b11;
        @(negedge clk);
        chk("R7 release", 32'(doe), 32'h0);
    endtask

    task automatic auto_pulse();
        @(negedge clk); oe_n[0] = 1'b0;
        @(negedge clk); oe_n[0] = 1'b1;
    endtask

    initial begin
        repeat (150_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 doe", 32'(doe), 32'h0);
        chk("R1 late", 32'(late), 32'h0);
        chk("R1 celong", 32'(celong), 32'h0);

        // R4 sweep: write every word through both strobes.
        for (int a = 0; a < 256; a++) wr_word(a, pat(a), 2'b11);
        for (int a = 0; a < 256; a++) rd_word(a);

        // R4 single-lane strobe write on the upper lane only.
        for (int a = 16; a < 24; a++) begin
            wr_word(a, 16'hC300 + 16'(a), 2'b10);
            rd_word(a);
        end

        // R5: lower lane captured on the chip-enable rising edge.
        for (int a = 40; a < 44; a++) begin
            @(negedge clk); ce_n = 1'b0; addr = AW'(a);
            @(negedge clk); we_n = 2'b10; din = 16'h7700 + 16'(a);
            @(negedge clk); ce_n = 1'b1; din = 16'h7700 + 16'(a);
            @(negedge clk); we_n = 2'b11; din = 16'h0;
            model[a][7:0] = 8'(a);
            rd_word(a);
        end

        // R6: upper lane reads while lower lane writes.
        @(negedge clk); ce_n = 1'b0; addr = 8'd77; oe_n = 2'b01; we_n = 2'b10; din = 16'h00E1;
        @(negedge clk);
        chk("R6 lanes", 32'(doe), 32'h2);
        chk("R6 upper byte", 32'(dout[15:8]), 32'(model[77][15:8]));
        we_n = 2'b11;
        @(negedge clk); ce_n = 1'b1; oe_n = 2'b11;
        model[77][7:0] = 8'hE1;
        rd_word(77);

        // R8: refresh-only cycle drives nothing and alters nothing.
        @(negedge clk); ce_n = 1'b0; addr = 8'd90;
        @(negedge clk); chk("R8 no drive", 32'(doe), 32'h0);
        @(negedge clk); ce_n = 1'b1;
        rd_word(90);

        // R7: auto refresh ignores address, strobes and data.
        @(negedge clk); addr = 8'd91; we_n = 2'b00; din = 16'hFFFF; oe_n = 2'b10;
        @(negedge clk); chk("R7 auto no drive", 32'(doe), 32'h0);
        @(negedge clk); chk("R9 auto no drive", 32'(doe), 32'h0);
        oe_n = 2'b11; we_n = 2'b11;
        rd_word(91);

        // R12: chip enable held low.
        @(negedge clk); ce_n = 1'b0; addr = 8'd3;
        repeat (900) @(negedge clk);
        chk("R12 short hold", 32'(celong), 32'h0);
        repeat (200) @(negedge clk);
        chk("R12 long hold", 32'(celong), 32'h1);
        ce_n = 1'b1;
        @(negedge clk); chk("R12 sticky", 32'(celong), 32'h1);

        // R10 / R11: coincident refreshes followed by a counter sweep.
        do_reset();
        while (cyc < 30_000) @(negedge clk);
        chk("R11 early", 32'(late), 32'h0);
        @(negedge clk); ce_n = 1'b0; addr = 8'd1;
        @(negedge clk);
        @(negedge clk); ce_n = 1'b1; oe_n[0] = 1'b0;
        @(negedge clk); oe_n[0] = 1'b1;
        for (int k = 0; k < 254; k++) auto_pulse();
        while (cyc < 45_000) @(negedge clk);
        chk("R10 all rows covered", 32'(late), 32'h0);
        chk("R9 counter sweep covered", 32'(late), 32'h0);
        while (cyc < 75_000) @(negedge clk);
        chk("R11 starvation", 32'(late), 32'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule